// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM. The host offers one access at a time through a valid/ready handshake. Each access carries an address, write data, a byte mask and a read/write flag. The block turns each access into a fixed sequence of registered strobes on the memory pins. When a read completes, it returns the read data with a one-cycle valid pulse.

Every phase length comes from the memory's minimum timing figures. These are given as parameters in nanoseconds together with the clock period, and each one is rounded up to a whole number of clock cycles. After reset the block waits out the long power-up settling time before it accepts anything. It ends every write with the rising edge of the write strobe and keeps the data driven for a hold time after that edge. It also inserts recovery cycles whenever the data bus changes direction. The data bus is split into an input, an output and a drive enable, so the pad ring can build the tri-state buffer.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low and every chip enable stays high for exactly P cycles, where P = ceil(T_POWER_NS/CLK_NS). `req_ready` first reads high after the P-th rising edge.
- R2: While reset is asserted, all chip enables, `mem_oe_n`, `mem_we_n` and all `mem_be_n` bits are high, and `mem_dq_oe`, `rsp_valid` and `req_ready` are low.
- R3: Each timing parameter is converted to cycles as max(1, ceil(t/CLK_NS)). The read phase length N_RD is the largest of the read cycle, address-to-data, chip-enable-to-data, output-enable-to-data and byte-enable-to-data counts.
- R4: A read holds all chip enables low, `mem_oe_n` low and `mem_we_n` high for exactly N_RD cycles. During that time `mem_addr` does not change and `mem_be_n[i]` is the inverse of mask bit i.
- R5: The read data is sampled at the last clock edge of the read phase. `rsp_valid` is high for exactly the one cycle after that edge. Byte lane i is `rsp_rdata[8i+7:8i]`: when mask bit i is set, the lane holds the sampled bus lane; otherwise it is zero.
- R6: A write holds `mem_we_n` low for exactly N_WP cycles. During that time all chip enables are low, `mem_oe_n` is high and `mem_dq_oe` is high, and `mem_be_n[i]` is low exactly where mask bit i is set. N_WP = max(setup count, chip-enable-to-end count, write-cycle count minus hold count, 1).
- R7: A write ends when `mem_we_n` rises. The data, the address and the chip enables stay in place for exactly N_WH = ceil(T_HD_NS/CLK_NS) (at least 1) cycles after that edge, and then `mem_dq_oe` falls.
- R8: Each write spends at least ceil(T_WC_NS/CLK_NS) cycles, counting the strobe cycles plus the hold cycles, with the bus driven.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low, and it is high only during a write.
- R10: When an access follows one of the other kind and the host offers it at once, the cycles with all chip enables high between the two accesses number 1 + ceil(T_HZ_NS/CLK_NS) for a read followed by a write, and 2 for a write followed by a read.
- R11: `req_ready` is high only while no access is in progress and all chip enables are high. Each accepted request produces exactly one strobe sequence, and accesses run in the order they were accepted.
- R12: When an access follows one of the same kind and the host offers it at once, exactly one cycle with all chip enables high separates the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Block accepts the offered access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/LANE_W | Byte lane mask, bit i selects lane i |
| rsp_valid | output | 1 | One-cycle pulse, read data present |
| rsp_rdata | output | DW | Read data, unselected lanes zero |
| mem_addr | output | AW | Memory address pins |
| mem_ce_n | output | NUM_CE | Active-low chip enables |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | DW/LANE_W | Active-low byte enables |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
A phase counter that is one count short shows up at the pins within the same access. A read strobe that ends one cycle early samples the bus before the bench's memory model has valid data, and the returned word carries a poison pattern. A write strobe of the wrong length is measured directly when `mem_we_n` rises. A wrong direction or turnaround state shows up in the count of idle cycles before the next access starts, or as the bus being driven while output enable is low. A power-up counter that is off by even one cycle moves the first rise of `req_ready`.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_PWR  = 3'd0,
      ST_IDLE = 3'd1,
      ST_TURN = 3'd2,
      ST_RD   = 3'd3,
      ST_WP   = 3'd4,
      ST_WH   = 3'd5
   } seq_state_e;

   // Round a time in nanoseconds up to whole clock cycles, never below one.
   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_pwr_gate.sv
module sram_pwr_gate #(
   parameter int N_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int CW = $clog2(N_CYC + 1);

   logic done_q;
   assign done = done_q;

   generate
      if (N_CYC <= 1) begin : g_short
         // The owning state machine adds one register, so the gate is open at once.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_q <= 1'b1;
            else        done_q <= 1'b1;
         end
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               cnt_q  <= cnt_q + 1'b1;
               done_q <= (32'(cnt_q) + 1 >= N_CYC - 1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // Last cycle of a phase loaded with load_val cycles.
   assign done = (cnt_q == TW'(1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
   parameter int DW     = 16,
   parameter int LANE_W = 8,
   parameter int BW     = DW / LANE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [BW-1:0] lane_en,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= cap_en;
   end

   generate
      for (genvar i = 0; i < BW; i++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata[i*LANE_W +: LANE_W] <= '0;
            else if (cap_en)
               rdata[i*LANE_W +: LANE_W] <= lane_en[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int AW         = 18,
   parameter int DW         = 16,
   parameter int LANE_W     = 8,
   parameter int NUM_CE     = 3,
   parameter int CLK_NS     = 10,
   parameter int T_POWER_NS = 1000000,
   parameter int T_RC_NS    = 10,
   parameter int T_AA_NS    = 10,
   parameter int T_ACE_NS   = 10,
   parameter int T_DOE_NS   = 5,
   parameter int T_DBE_NS   = 5,
   parameter int T_WC_NS    = 10,
   parameter int T_SCE_NS   = 7,
   parameter int T_SD_NS    = 5,
   parameter int T_HD_NS    = 1,
   parameter int T_HZ_NS    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [DW-1:0]        req_wdata,
   input  logic [DW/LANE_W-1:0] req_mask,
   output logic                 rsp_valid,
   output logic [DW-1:0]        rsp_rdata,
   output logic [AW-1:0]        mem_addr,
   output logic [NUM_CE-1:0]    mem_ce_n,
   output logic                 mem_oe_n,
   output logic                 mem_we_n,
   output logic [DW/LANE_W-1:0] mem_be_n,
   output logic [DW-1:0]        mem_dq_out,
   output logic                 mem_dq_oe,
   input  logic [DW-1:0]        mem_dq_in
);
   localparam int BW        = DW / LANE_W;
   localparam int N_PWR     = ns_to_cyc(T_POWER_NS, CLK_NS);
   localparam int N_RD      = imax(imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                        imax(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS))),
                                   ns_to_cyc(T_DBE_NS, CLK_NS));
   localparam int N_WH      = ns_to_cyc(T_HD_NS, CLK_NS);
   localparam int N_WC      = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int N_WP      = imax(imax(ns_to_cyc(T_SCE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                   imax(N_WC - N_WH, 1));
   localparam int N_HZ      = ns_to_cyc(T_HZ_NS, CLK_NS);
   localparam int N_TURN_WR = 1;
   localparam int N_MAXPH   = imax(imax(N_RD, N_WP), imax(N_WH, N_HZ));
   localparam int TW        = $clog2(N_MAXPH + 1);

   // Elaboration-time parameter checks
   generate
      if (LANE_W < 1 || DW % LANE_W != 0) begin : g_bad_lane
         $error("DW must be a whole multiple of LANE_W");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("CLK_NS must be at least 1");
      end
      if (NUM_CE < 1 || AW < 1) begin : g_bad_pins
         $error("NUM_CE and AW must be at least 1");
      end
   endgenerate

   seq_state_e       state_q;
   logic             ready_q;
   logic             op_wr_q;
   logic [AW-1:0]    op_addr_q;
   logic [DW-1:0]    op_wdata_q;
   logic [BW-1:0]    op_mask_q;
   logic             last_vld_q;
   logic             last_wr_q;

   logic [AW-1:0]     addr_q;
   logic [NUM_CE-1:0] ce_n_q;
   logic              oe_n_q;
   logic              we_n_q;
   logic [BW-1:0]     be_n_q;
   logic [DW-1:0]     dq_out_q;
   logic              dq_oe_q;

   logic          pwr_done;
   logic          t_load;
   logic [TW-1:0] t_val;
   logic          t_done;

   logic          accept;
   logic          turn_need;
   logic          go;
   logic          go_wr;
   logic [AW-1:0] go_addr;
   logic [DW-1:0] go_wdata;
   logic [BW-1:0] go_mask;
   logic          cap_go;

   sram_pwr_gate #(.N_CYC(N_PWR)) u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_done)
   );

   sram_phase_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   sram_rd_capture #(.DW(DW), .LANE_W(LANE_W), .BW(BW)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_go),
      .lane_en (op_mask_q),
      .dq_in   (mem_dq_in),
      .rdata   (rsp_rdata),
      .rvalid  (rsp_valid)
   );

   always_comb begin
      accept    = (state_q == ST_IDLE) && req_valid;
      turn_need = last_vld_q && (last_wr_q != req_write);
      go        = (accept && !turn_need) || ((state_q == ST_TURN) && t_done);
      if (state_q == ST_IDLE) begin
         go_wr    = req_write;
         go_addr  = req_addr;
         go_wdata = req_wdata;
         go_mask  = req_mask;
      end else begin
         go_wr    = op_wr_q;
         go_addr  = op_addr_q;
         go_wdata = op_wdata_q;
         go_mask  = op_mask_q;
      end
      t_load = 1'b0;
      t_val  = '0;
      if (accept && turn_need) begin
         t_load = 1'b1;
         t_val  = req_write ? TW'(N_HZ) : TW'(N_TURN_WR);
      end
      if (go) begin
         t_load = 1'b1;
         t_val  = go_wr ? TW'(N_WP) : TW'(N_RD);
      end
      if ((state_q == ST_WP) && t_done) begin
         t_load = 1'b1;
         t_val  = TW'(N_WH);
      end
      cap_go = (state_q == ST_RD) && t_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_PWR;
         ready_q    <= 1'b0;
         op_wr_q    <= 1'b0;
         op_addr_q  <= '0;
         op_wdata_q <= '0;
         op_mask_q  <= '0;
         last_vld_q <= 1'b0;
         last_wr_q  <= 1'b0;
         addr_q     <= '0;
         ce_n_q     <= '1;
         oe_n_q     <= 1'b1;
         we_n_q     <= 1'b1;
         be_n_q     <= '1;
         dq_out_q   <= '0;
         dq_oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_PWR: begin
               if (pwr_done) begin
                  state_q <= ST_IDLE;
                  ready_q <= 1'b1;
               end
            end
            ST_IDLE: begin
               if (req_valid) begin
                  op_wr_q    <= req_write;
                  op_addr_q  <= req_addr;
                  op_wdata_q <= req_wdata;
                  op_mask_q  <= req_mask;
                  last_vld_q <= 1'b1;
                  last_wr_q  <= req_write;
                  ready_q    <= 1'b0;
                  if (turn_need)      state_q <= ST_TURN;
                  else if (req_write) state_q <= ST_WP;
                  else                state_q <= ST_RD;
               end
            end
            ST_TURN: begin
               if (t_done) state_q <= op_wr_q ? ST_WP : ST_RD;
            end
            ST_RD: begin
               if (t_done) begin
                  state_q <= ST_IDLE;
                  ready_q <= 1'b1;
                  ce_n_q  <= '1;
                  oe_n_q  <= 1'b1;
                  be_n_q  <= '1;
               end
            end
            ST_WP: begin
               if (t_done) begin
                  state_q <= ST_WH;
                  we_n_q  <= 1'b1;
               end
            end
            ST_WH: begin
               if (t_done) begin
                  state_q <= ST_IDLE;
                  ready_q <= 1'b1;
                  ce_n_q  <= '1;
                  be_n_q  <= '1;
                  dq_oe_q <= 1'b0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (go) begin
            addr_q  <= go_addr;
            ce_n_q  <= '0;
            be_n_q  <= ~go_mask;
            oe_n_q  <= go_wr;
            we_n_q  <= !go_wr;
            dq_oe_q <= go_wr;
            if (go_wr) dq_out_q <= go_wdata;
         end
      end
   end

   assign req_ready  = ready_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = ce_n_q;
   assign mem_oe_n   = oe_n_q;
   assign mem_we_n   = we_n_q;
   assign mem_be_n   = be_n_q;
   assign mem_dq_out = dq_out_q;
   assign mem_dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
   import sram_seq_pkg::*;
#(
   parameter int AW         = 18,
   parameter int NUM_CE     = 3,
   parameter int CLK_NS     = 10,
   parameter int T_POWER_NS = 1000000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [AW-1:0]     mem_addr,
   input logic [NUM_CE-1:0] mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe
);
   localparam int P_CYC = ns_to_cyc(T_POWER_NS, CLK_NS);

   int pwr_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pwr_cnt <= 0;
      else if (pwr_cnt < P_CYC) pwr_cnt <= pwr_cnt + 1;
   end

   // R1
   pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (pwr_cnt >= P_CYC));

   // R9
   dq_drive_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R6
   we_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_ce_n == '0 && mem_oe_n && mem_dq_oe));

   // R7
   we_end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && mem_ce_n == '0));

   // R4
   rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_ce_n == '0 && mem_we_n && !mem_dq_oe));

   // R4
   rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr));

   // R5
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R11
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n == '1 && !mem_dq_oe));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
   .AW         (AW),
   .NUM_CE     (NUM_CE),
   .CLK_NS     (CLK_NS),
   .T_POWER_NS (T_POWER_NS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;
   localparam int AW = 6, DW = 16, LW = 8, BW = DW / LW, NCE = 3, CLKP = 10;
   localparam int TPW = 1500, TRC = 30, TAA = 25, TACE = 20, TDOE = 12, TDBE = 12;
   localparam int TWC = 50, TSCE = 27, TSD = 15, THD = 12, THZ = 25;

   function automatic int cyc(input int t);
      int c;
      c = (t + CLKP - 1) / CLKP;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_PWR = cyc(TPW);
   localparam int E_RD  = mx(mx(mx(cyc(TRC), cyc(TAA)), mx(cyc(TACE), cyc(TDOE))), cyc(TDBE));
   localparam int E_WH  = cyc(THD);
   localparam int E_WC  = cyc(TWC);
   localparam int E_WP  = mx(mx(cyc(TSCE), cyc(TSD)), mx(E_WC - E_WH, 1));
   localparam int E_HZ  = cyc(THZ);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BW-1:0] req_mask = '0;
   logic req_ready, rsp_valid, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [NCE-1:0] mem_ce_n;
   logic [BW-1:0] mem_be_n;

   always #5 clk = ~clk;

   sram_seq_ctrl #(
      .AW(AW), .DW(DW), .LANE_W(LW), .NUM_CE(NCE), .CLK_NS(CLKP), .T_POWER_NS(TPW),
      .T_RC_NS(TRC), .T_AA_NS(TAA), .T_ACE_NS(TACE), .T_DOE_NS(TDOE), .T_DBE_NS(TDBE),
      .T_WC_NS(TWC), .T_SCE_NS(TSCE), .T_SD_NS(TSD), .T_HD_NS(THD), .T_HZ_NS(THZ)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] mem    [64];
   logic [DW-1:0] shadow [64];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Memory model: data valid only after E_RD strobe cycles, poison before.
   int rd_age = 0;
   always @(posedge clk) rd_age <= (mem_ce_n == '0 && !mem_oe_n) ? rd_age + 1 : 0;

   always_comb begin
      mem_dq_in = 16'hBAD5;
      if (mem_ce_n == '0 && !mem_oe_n && rd_age >= E_RD - 1)
         for (int i = 0; i < BW; i++)
            mem_dq_in[i*LW +: LW] = !mem_be_n[i] ? mem[mem_addr][i*LW +: LW] : 8'hEE;
   end

   // Pin monitor
   int gap = 0, last_type = 0, we_run = 0, wp_len = 0, hold_run = 0, oe_run = 0;
   bit in_hold = 0, prev_ce_hi = 1, prev_we_n = 1, prev_oe_n = 1;
   logic [AW-1:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_oe_n) chk(0, "R9", "bus driven with oe low", 1, 0);
         if (mem_ce_n == '1) gap++;
         else if (prev_ce_hi) begin
            int cur, exp_gap;
            cur = !mem_oe_n ? 1 : 2;
            if (last_type != 0) begin
               exp_gap = (last_type == cur) ? 1 : ((cur == 2) ? 1 + E_HZ : 2);
               chk(gap == exp_gap, (last_type == cur) ? "R12" : "R10", "idle gap", gap, exp_gap);
            end
            last_type = cur;
            gap = 0;
         end
         if (!mem_oe_n) begin
            oe_run++;
            if (oe_run > 1 && mem_addr != prev_addr) chk(0, "R4", "addr moved", mem_addr, prev_addr);
         end else if (!prev_oe_n) begin
            chk(oe_run == E_RD, "R4", "read strobe len", oe_run, E_RD);
            chk(rsp_valid, "R5", "rsp_valid after read", rsp_valid, 1);
            oe_run = 0;
         end else if (rsp_valid) chk(0, "R5", "stray rsp_valid", 1, 0);
         if (!mem_we_n) begin
            we_run++;
            if (mem_dq_oe !== 1'b1) chk(0, "R6", "bus not driven in write", mem_dq_oe, 1);
         end else if (!prev_we_n) begin
            chk(we_run == E_WP, "R6", "write strobe len", we_run, E_WP);
            chk(mem_dq_oe && mem_ce_n == '0, "R7", "hold after we rise", mem_dq_oe, 1);
            for (int i = 0; i < BW; i++)
               if (!mem_be_n[i]) mem[mem_addr][i*LW +: LW] = mem_dq_out[i*LW +: LW];
            wp_len = we_run; we_run = 0; hold_run = 1; in_hold = 1;
         end else if (in_hold) begin
            if (mem_dq_oe) hold_run++;
            else begin
               chk(hold_run == E_WH, "R7", "hold len", hold_run, E_WH);
               chk(wp_len + hold_run >= E_WC, "R8", "write total", wp_len + hold_run, E_WC);
               in_hold = 0;
            end
         end
         prev_ce_hi = (mem_ce_n == '1);
         prev_we_n  = mem_we_n;
         prev_oe_n  = mem_oe_n;
         prev_addr  = mem_addr;
      end
   end

   function automatic logic [DW-1:0] exp_rd(input int a, input logic [BW-1:0] m);
      logic [DW-1:0] r;
      for (int i = 0; i < BW; i++) r[i*LW +: LW] = m[i] ? shadow[a][i*LW +: LW] : '0;
      return r;
   endfunction

   // Called at a negedge; returns at a negedge with the next op free to start.
   task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d, input logic [BW-1:0] m);
      req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_mask = m;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      if (wr) begin
         for (int i = 0; i < BW; i++) if (m[i]) shadow[a][i*LW +: LW] = d[i*LW +: LW];
      end else begin
         int lim = 0;
         while (!rsp_valid && lim < 50) begin @(negedge clk); lim++; end
         chk(rsp_rdata == exp_rd(a, m), "R5", "read data", rsp_rdata, exp_rd(a, m));
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int pc;
      bit ce_ok;
      for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R2 reset state
      chk(mem_ce_n == '1 && mem_oe_n && mem_we_n && mem_be_n == '1, "R2", "strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n}, '1);
      chk(!mem_dq_oe && !rsp_valid && !req_ready, "R2", "oe/valid/ready in reset",
          {mem_dq_oe, rsp_valid, req_ready}, 0);
      rst_n = 1;
      // R1 power-up hold-off, with a request pending the whole time
      req_valid = 1; req_write = 0; req_addr = '0; req_mask = '1;
      pc = 0; ce_ok = 1;
      while (!req_ready && pc < 1000) begin
         @(posedge clk); pc++;
         @(negedge clk);
         if (mem_ce_n != '1) ce_ok = 0;
      end
      chk(pc == E_PWR, "R1", "power-up cycles", pc, E_PWR);
      chk(ce_ok, "R1", "chip enables high in hold-off", ce_ok, 1);
      // Directed corners (R3 phase lengths, R11 ordering, R10/R12 gaps)
      do_op(0, 0, '0, 2'b11);
      do_op(1, 0, 16'hA55A, 2'b11);
      do_op(1, 63, 16'h1234, 2'b11);
      do_op(1, 63, 16'hFF00, 2'b10);
      do_op(0, 63, '0, 2'b11);
      do_op(0, 63, '0, 2'b01);
      do_op(1, 0, 16'h00C3, 2'b01);
      do_op(0, 0, '0, 2'b10);
      do_op(0, 0, '0, 2'b11);
      do_op(1, 5, 16'h7777, 2'b00);
      do_op(0, 5, '0, 2'b11);
      // Constrained random traffic
      for (int k = 0; k < 80; k++) begin
         int unsigned r;
         r = $urandom;
         do_op(r[0], int'(r[6:1]), 16'($urandom), r[8:7]);
      end
      repeat (12) @(negedge clk);
      finish_run();
   end
endmodule